// File: doc/BRIEF.md
# Compare Channel with Period-Reset Event

This block holds two free-running 16-bit timers and one compare channel that watches whichever timer the select input picks. Software loads a compare value and a 4-bit mode. In either compare mode, a new equality between the compare value and the selected count sets a sticky compare flag. In the event mode, the same match also zeroes the selected timer and emits a one-clock event pulse. The compare value then acts as a programmable period of `cmp + 1` counts.

Two build options shape each instance. `HAS_TRIG` decides whether the event mode exists at all. Without it, the event code behaves as plain compare-with-flag. `HAS_ADC` decides whether an event also raises a one-clock conversion request, gated by the A/D enable input. A clear caused by an event never counts as a timer overflow.

Top module: `cmp_event_unit`

## Requirements
- R1: After reset, both counts, both overflow flags, the compare flag, `evt_pulse` and `adc_start` are 0, the mode is 4'b0000 (inactive) and the compare value is 0.
- R2: Each timer adds one on every clock where its enable is high and wraps from 16'hFFFF to 0. A wrap sets that timer's sticky overflow flag. A high level on the timer's clear input zeroes the flag, except that a wrap in the same cycle wins.
- R3: With mode 4'b1010 or 4'b1011, a match is the compare value equal to the selected count (`tmr_sel` 0 = timer A, 1 = timer B). A new match sets `cmp_flag` at the next edge. The flag stays set until `cmp_flag_clr`, and a set in the same cycle wins over the clear.
- R4: One match gives one response: while the equality persists across cycles, no further event or request is produced.
- R5: In mode 4'b1011 on an instance with the trigger built, `evt_pulse` is high for exactly the one cycle after the match cycle. In that same cycle the selected timer reads 0 instead of incrementing, so consecutive events are `cmp + 1` cycles apart. The unselected timer is not affected.
- R6: A clear caused by an event never sets the overflow flag, even when the compare value is 16'hFFFF.
- R7: `adc_start` pulses together with `evt_pulse` only when the ADC option is built and `adc_enable` is high. It is never high otherwise.
- R8: On an instance built without the trigger, mode 4'b1011 sets the compare flag only. It produces no event, no timer clear and no conversion request.
- R9: Any mode other than 4'b1010 and 4'b1011 produces no compare flag, no event and no request.
- R10: Mode 4'b1010 sets the compare flag on a match without clearing a timer or pulsing `evt_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Load `mode_wdata` into the mode register |
| mode_wdata | input | 4 | New mode value |
| cmp_wr | input | 1 | Load `cmp_wdata` into the compare register |
| cmp_wdata | input | W | New compare value |
| tmr_sel | input | 1 | Timer watched by the channel: 0 = A, 1 = B |
| tmr_en_a | input | 1 | Count enable, timer A |
| tmr_en_b | input | 1 | Count enable, timer B |
| adc_enable | input | 1 | Allows an event to request a conversion |
| cmp_flag_clr | input | 1 | Write-one-to-clear for `cmp_flag` |
| ovf_clr_a | input | 1 | Write-one-to-clear for `ovf_a` |
| ovf_clr_b | input | 1 | Write-one-to-clear for `ovf_b` |
| cnt_a | output | W | Timer A count |
| cnt_b | output | W | Timer B count |
| ovf_a | output | 1 | Timer A overflow flag |
| ovf_b | output | 1 | Timer B overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |
| evt_pulse | output | 1 | One-cycle event pulse |
| adc_start | output | 1 | One-cycle conversion request |

## Verification
The bench runs a trigger-and-ADC instance and a bare instance side by side. The key corner is a compare value of 16'hFFFF in event mode. A design that treated the clear as a wrap would raise the overflow flag there, and the bare instance must raise it through a real wrap. A compare value of 0 with the timers stopped holds the equality for many cycles. A design without edge detection would pulse repeatedly. Random mode changes, timer-select flips and clear/set collisions check that the flag set wins, that the unselected timer is never zeroed, and that a period is `cmp + 1` cycles rather than an off-by-one value.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_CMP_FLAG = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_CMP_EVT  = 4'b1011;

    typedef struct packed {
        logic prev;
        logic flag;
        logic evt;
        logic adc;
    } match_st_t;

    function automatic logic mode_is_active(input logic [MODE_W-1:0] m);
        return (m == MODE_CMP_FLAG) || (m == MODE_CMP_EVT);
    endfunction

endpackage

// File: rtl/cmp_evt_timer.sv
module cmp_evt_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = en && !clr && (&st_q.cnt);
        if (clr) begin
            st_d.cnt = '0;
        end else if (en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.ovf = wrap | (st_q.ovf & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !$rose(ovf));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));

endmodule

// File: rtl/cmp_evt_match.sv
module cmp_evt_match
    import cmp_event_pkg::*;
#(
    parameter int W        = 16,
    parameter bit HAS_TRIG = 1'b1,
    parameter bit HAS_ADC  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      cmp_val,
    input  logic [W-1:0]      cnt_sel,
    input  logic              adc_en,
    input  logic              flag_clr,
    output logic              clr_req,
    output logic              flag,
    output logic              evt,
    output logic              adc
);

    match_st_t st_d, st_q;
    logic      active;
    logic      evt_mode;
    logic      hit;
    logic      fire;

    always_comb begin
        active   = mode_is_active(mode);
        evt_mode = HAS_TRIG && (mode == MODE_CMP_EVT);
        hit      = active && (cmp_val == cnt_sel);
        fire     = hit && !st_q.prev;
        clr_req  = fire && evt_mode;

        st_d      = st_q;
        st_d.prev = hit;
        st_d.flag = fire | (st_q.flag & ~flag_clr);
        st_d.evt  = clr_req;
        st_d.adc  = clr_req && HAS_ADC && adc_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign evt  = st_q.evt;
    assign adc  = st_q.adc;

    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag);

    a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    a_r7_adc_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
        adc |-> evt);

    a_r9_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!evt && !adc && (flag -> $past(flag))));

    generate
        if (!HAS_TRIG) begin : g_no_trig
            a_r8_no_event: assert property (@(posedge clk) disable iff (!rst_n)
                !evt && !clr_req);
        end
        if (!HAS_ADC) begin : g_no_adc
            a_r7_no_adc: assert property (@(posedge clk) disable iff (!rst_n)
                !adc);
        end
    endgenerate

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
    import cmp_event_pkg::*;
#(
    parameter int W        = 16,
    parameter bit HAS_TRIG = 1'b1,
    parameter bit HAS_ADC  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cmp_wr,
    input  logic [W-1:0]      cmp_wdata,
    input  logic              tmr_sel,
    input  logic              tmr_en_a,
    input  logic              tmr_en_b,
    input  logic              adc_enable,
    input  logic              cmp_flag_clr,
    input  logic              ovf_clr_a,
    input  logic              ovf_clr_b,
    output logic [W-1:0]      cnt_a,
    output logic [W-1:0]      cnt_b,
    output logic              ovf_a,
    output logic              ovf_b,
    output logic              cmp_flag,
    output logic              evt_pulse,
    output logic              adc_start
);

    localparam int N_TMR = 2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [W-1:0]      cmp;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    logic [N_TMR-1:0] en_v;
    logic [N_TMR-1:0] oclr_v;
    logic [N_TMR-1:0] clr_v;
    logic [N_TMR-1:0] ovf_v;
    logic [W-1:0]     cnt_v [N_TMR];
    logic [W-1:0]     cnt_sel;
    logic             clr_req;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr) cfg_d.mode = mode_wdata;
        if (cmp_wr)  cfg_d.cmp  = cmp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_v   = {tmr_en_b, tmr_en_a};
    assign oclr_v = {ovf_clr_b, ovf_clr_a};

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            assign clr_v[i] = clr_req && (tmr_sel == i[0]);
            cmp_evt_timer #(.W(W)) tmr_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_v[i]),
                .clr     (clr_v[i]),
                .ovf_clr (oclr_v[i]),
                .cnt     (cnt_v[i]),
                .ovf     (ovf_v[i])
            );
        end
    endgenerate

    assign cnt_sel = tmr_sel ? cnt_v[1] : cnt_v[0];

    cmp_evt_match #(.W(W), .HAS_TRIG(HAS_TRIG), .HAS_ADC(HAS_ADC)) match_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_q.mode),
        .cmp_val  (cfg_q.cmp),
        .cnt_sel  (cnt_sel),
        .adc_en   (adc_enable),
        .flag_clr (cmp_flag_clr),
        .clr_req  (clr_req),
        .flag     (cmp_flag),
        .evt      (evt_pulse),
        .adc      (adc_start)
    );

    assign cnt_a = cnt_v[0];
    assign cnt_b = cnt_v[1];
    assign ovf_a = ovf_v[0];
    assign ovf_b = ovf_v[1];

    a_r5_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !tmr_sel && tmr_en_b) |=> (cnt_b == $past(cnt_b) + 1'b1));

    a_r5_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clr_v) <= 1);

endmodule

// File: tb/cmp_event_unit_tb_top.sv
module cmp_event_unit_tb_top;

    localparam time CLK_P = 10ns;
    localparam int  W     = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_wr = 0, cmp_wr = 0, tmr_sel = 0;
    logic         tmr_en_a = 0, tmr_en_b = 0, adc_enable = 0;
    logic         cmp_flag_clr = 0, ovf_clr_a = 0, ovf_clr_b = 0;
    logic [3:0]   mode_wdata = 0;
    logic [W-1:0] cmp_wdata = 0;

    logic [W-1:0] o_cnt_a [2];
    logic [W-1:0] o_cnt_b [2];
    logic         o_ovf_a [2];
    logic         o_ovf_b [2];
    logic         o_flag  [2];
    logic         o_evt   [2];
    logic         o_adc   [2];

    int n_checks = 0;
    int n_errors = 0;
    bit chk_on   = 0;
    bit done     = 0;

    always #(CLK_P/2) clk = ~clk;

    cmp_event_unit #(.W(W), .HAS_TRIG(1'b1), .HAS_ADC(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .tmr_sel(tmr_sel),
        .tmr_en_a(tmr_en_a), .tmr_en_b(tmr_en_b), .adc_enable(adc_enable),
        .cmp_flag_clr(cmp_flag_clr), .ovf_clr_a(ovf_clr_a), .ovf_clr_b(ovf_clr_b),
        .cnt_a(o_cnt_a[0]), .cnt_b(o_cnt_b[0]), .ovf_a(o_ovf_a[0]), .ovf_b(o_ovf_b[0]),
        .cmp_flag(o_flag[0]), .evt_pulse(o_evt[0]), .adc_start(o_adc[0])
    );

    cmp_event_unit #(.W(W), .HAS_TRIG(1'b0), .HAS_ADC(1'b0)) dut_nt_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .tmr_sel(tmr_sel),
        .tmr_en_a(tmr_en_a), .tmr_en_b(tmr_en_b), .adc_enable(adc_enable),
        .cmp_flag_clr(cmp_flag_clr), .ovf_clr_a(ovf_clr_a), .ovf_clr_b(ovf_clr_b),
        .cnt_a(o_cnt_a[1]), .cnt_b(o_cnt_b[1]), .ovf_a(o_ovf_a[1]), .ovf_b(o_ovf_b[1]),
        .cmp_flag(o_flag[1]), .evt_pulse(o_evt[1]), .adc_start(o_adc[1])
    );

    // Expected-value model built from the requirements; k=0 full build, k=1 bare build
    logic [W-1:0] m_cnt  [2][2];
    logic         m_ovf  [2][2];
    logic         m_flag [2];
    logic         m_evt  [2];
    logic         m_adc  [2];
    logic         m_prev [2];
    logic [3:0]   m_mode;
    logic [W-1:0] m_cmp;

    function automatic bit mode_on(input logic [3:0] m);
        return (m == 4'b1010) || (m == 4'b1011);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                for (int t = 0; t < 2; t++) begin
                    m_cnt[k][t] = '0;
                    m_ovf[k][t] = 1'b0;
                end
                m_flag[k] = 0; m_evt[k] = 0; m_adc[k] = 0; m_prev[k] = 0;
            end
            m_mode = '0;
            m_cmp  = '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit hit, fire, evt_mode, en, oclr, clr, wrap;
                hit      = mode_on(m_mode) && (m_cmp == m_cnt[k][tmr_sel]);
                fire     = hit && !m_prev[k];
                evt_mode = (k == 0) && (m_mode == 4'b1011);
                for (int t = 0; t < 2; t++) begin
                    en   = (t == 0) ? tmr_en_a : tmr_en_b;
                    oclr = (t == 0) ? ovf_clr_a : ovf_clr_b;
                    clr  = fire && evt_mode && (tmr_sel == t[0]);
                    wrap = en && !clr && (m_cnt[k][t] == 16'hFFFF);
                    if (clr)     m_cnt[k][t] = '0;
                    else if (en) m_cnt[k][t] = m_cnt[k][t] + 1'b1;
                    m_ovf[k][t] = wrap || (m_ovf[k][t] && !oclr);
                end
                m_flag[k] = fire || (m_flag[k] && !cmp_flag_clr);
                m_evt[k]  = fire && evt_mode;
                m_adc[k]  = fire && evt_mode && (k == 0) && adc_enable;
                m_prev[k] = hit;
            end
            if (mode_wr) m_mode = mode_wdata;
            if (cmp_wr)  m_cmp  = cmp_wdata;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            for (int k = 0; k < 2; k++) begin
                string rq;
                rq = (k == 0) ? "R5" : "R8";
                chk(rq, "cnt_a", o_cnt_a[k], m_cnt[k][0]);
                chk(rq, "cnt_b", o_cnt_b[k], m_cnt[k][1]);
                chk("R2", "ovf_a", o_ovf_a[k], m_ovf[k][0]);
                chk("R6", "ovf_b", o_ovf_b[k], m_ovf[k][1]);
                chk("R3", "cmp_flag", o_flag[k], m_flag[k]);
                chk("R4", "evt_pulse", o_evt[k], m_evt[k]);
                chk("R7", "adc_start", o_adc[k], m_adc[k]);
            end
        end
    end

    task automatic drive_idle();
        mode_wr = 0; cmp_wr = 0; cmp_flag_clr = 0; ovf_clr_a = 0; ovf_clr_b = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 0;
        drive_idle();
        tmr_en_a = 0; tmr_en_b = 0; tmr_sel = 0; adc_enable = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic [W-1:0] c);
        @(negedge clk); #1;
        mode_wr = 1; mode_wdata = m; cmp_wr = 1; cmp_wdata = c;
        @(negedge clk); #1;
        drive_idle();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int gap;
        void'($urandom(32'd20250611));
        do_reset();
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 2; k++) begin
            chk("R1", "cnt_a", o_cnt_a[k], 0);
            chk("R1", "cnt_b", o_cnt_b[k], 0);
            chk("R1", "ovf", o_ovf_a[k] | o_ovf_b[k], 0);
            chk("R1", "flag/evt/adc", o_flag[k] | o_evt[k] | o_adc[k], 0);
        end
        chk_on = 1;

        // R5/R7: period of cmp+1 cycles, ADC request while enabled
        #1 tmr_en_a = 1; tmr_en_b = 1; adc_enable = 1;
        set_cfg(4'b1011, 16'd5);
        gap = 0;
        while (!o_evt[0] && gap < 100) begin @(negedge clk); gap++; end
        chk("R7", "adc with first event", o_adc[0], 1);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!o_evt[0] && gap < 100);
        chk("R5", "event spacing", gap, 6);
        chk("R8", "bare build timer A beyond cmp", (o_cnt_a[1] > 5) ? 1 : 0, 1);
        #1 adc_enable = 0;
        repeat (20) @(negedge clk);

        // R10: flag-only mode, no clear
        set_cfg(4'b1010, 16'd3);
        repeat (30) @(negedge clk);
        chk("R10", "no event in flag mode", o_evt[0], 0);

        // R4: equality held with stopped timers and cmp = 0
        do_reset();
        @(negedge clk); #1;
        mode_wr = 1; mode_wdata = 4'b1011;
        @(negedge clk); #1 drive_idle();
        repeat (10) @(negedge clk);
        chk("R4", "flag after held match", o_flag[0], 1);
        chk("R4", "no repeat event", o_evt[0], 0);

        // R9: inactive mode
        set_cfg(4'b0111, 16'd2);
        #1 cmp_flag_clr = 1; tmr_en_a = 1;
        @(negedge clk); #1 cmp_flag_clr = 0;
        repeat (10) @(negedge clk);
        chk("R9", "flag in inactive mode", o_flag[0], 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            mode_wr = ($urandom_range(0, 19) == 0);
            case ($urandom_range(0, 3))
                0: mode_wdata = 4'b1010;
                1, 2: mode_wdata = 4'b1011;
                default: mode_wdata = 4'($urandom);
            endcase
            cmp_wr       = ($urandom_range(0, 19) == 0);
            cmp_wdata    = 16'($urandom_range(0, 40));
            if ($urandom_range(0, 9) == 0) tmr_sel = ~tmr_sel;
            tmr_en_a     = ($urandom_range(0, 9) != 0);
            tmr_en_b     = ($urandom_range(0, 9) != 0);
            adc_enable   = 1'($urandom);
            cmp_flag_clr = ($urandom_range(0, 7) == 0);
            ovf_clr_a    = ($urandom_range(0, 7) == 0);
            ovf_clr_b    = ($urandom_range(0, 7) == 0);
        end
        @(negedge clk); #1 drive_idle();

        // R6/R2/R8: compare value at the top of the range
        do_reset();
        #1 tmr_sel = 0;
        set_cfg(4'b1011, 16'hFFFF);
        #1 tmr_en_a = 1; tmr_en_b = 1;
        repeat (65545) @(negedge clk);
        chk("R6", "no overflow from event clear", o_ovf_a[0], 0);
        chk("R2", "timer B wrap flag", o_ovf_b[0], 1);
        chk("R8", "bare build wraps timer A", o_ovf_a[1], 1);
        #1 ovf_clr_b = 1;
        @(negedge clk); #1 ovf_clr_b = 0;
        chk("R2", "overflow cleared", o_ovf_b[0], 0);

        chk_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule